// File: doc/BRIEF.md
# Low-Frequency RFID Reader Carrier Control Sequencer

This block is the digital sequencer that sits beside the analog parts of a low-frequency RFID reader. It receives a carrier waveform and a one-cycle tick that marks the start of each carrier period, both already in the system clock domain. It also receives three asynchronous controls: a sleep request, a field-modulation request and an antenna short flag. From these it drives the output-enable and data lines of two antiphase antenna drivers, a ready/clock pin with its own output enable and weak pull-down control, and an enable and a hold strobe for the loop oscillator and receive chain.

After the sleep request is dropped, the block settles for a set number of carrier periods. During that time the field is on and the ready/clock pin is only weakly pulled down. After settling, the ready/clock pin carries the carrier. A modulation request switches the field off and on only at carrier-period boundaries. It freezes the receive chain, and the freeze ends a fixed number of carrier periods after the request is dropped. A short flag latches a fault that only sleep clears. A mode input selects between bridge drive and single-ended AM drive. In single-ended AM drive, modulation switches off only the first driver.

Top module: `lfr_carrier_seq`

## Requirements
- R1: Out of reset the block is asleep: both antenna enables are 0, `rc_oe`=1 with `rc_dat`=0 and `rc_pulldn`=0, and `rx_en`=0 and `rx_hold`=0.
- R2: `sleep_req`, `mod_req` and `short_flag` each pass a two-flop synchroniser, so a change acts on the state at the third rising clock edge. A synchronised sleep request forces the sleep outputs of R1 from any state, including a latched fault.
- R3: After the synchronised sleep request goes low, the block settles for SETTLE_TICKS carrier ticks. While it settles, the antenna drivers are on (unless gated), `rx_en`=1, `rc_oe`=0 and `rc_pulldn`=1. After the SETTLE_TICKS-th tick it runs, and `rc_oe`=1, `rc_pulldn`=0.
- R4: `ant_a_dat` always follows `car_lvl` and `ant_b_dat` is always its complement.
- R5: The field gate samples the synchronised modulation request only in a cycle with `car_tick`=1. An antenna enable therefore changes only in the cycle after a tick, or on a state change.
- R6: While the synchronised modulation request is high, `rx_hold`=1. After it falls, `rx_hold` drops in the cycle after the REL_TICKS-th (default 41) following carrier tick. A new request during that wait restarts the count.
- R7: While running, `rc_dat` equals `car_lvl` with `rc_oe`=1, whether or not modulation is active.
- R8: With `am_single`=0, a gated field turns off both `ant_a_oe` and `ant_b_oe`. With `am_single`=1, only `ant_a_oe` turns off and `ant_b_oe` stays on.
- R9: A synchronised short flag while settling or running moves the block to a fault state. In the fault state both antenna enables are 0, `rc_oe`=1 with `rc_dat`=0, and `rx_en`=0. The fault holds until a sleep request. A short flag while asleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| car_lvl | input | 1 | Carrier waveform level |
| car_tick | input | 1 | One-cycle pulse at the start of each carrier period |
| sleep_req | input | 1 | Asynchronous sleep request, high = sleep |
| mod_req | input | 1 | Asynchronous field-modulation request, high = field off |
| short_flag | input | 1 | Asynchronous antenna short indication |
| am_single | input | 1 | 1 = single-ended AM drive, 0 = bridge drive (static) |
| ant_a_oe | output | 1 | First antenna driver enable |
| ant_a_dat | output | 1 | First antenna driver phase |
| ant_b_oe | output | 1 | Second antenna driver enable |
| ant_b_dat | output | 1 | Second antenna driver phase (antiphase) |
| rc_oe | output | 1 | Ready/clock pin active drive enable |
| rc_dat | output | 1 | Ready/clock pin data |
| rc_pulldn | output | 1 | Ready/clock weak pull-down enable |
| rx_en | output | 1 | Oscillator and receive chain enable |
| rx_hold | output | 1 | Oscillator and receive chain operating-point hold |

## Verification
The hardest situation to reach is a new modulation request that arrives partway through the 41-tick release window. The request has to pass the synchroniser and then reload the counter, while the field gate still waits for the next carrier boundary. The stimulus reaches it by dropping modulation, waiting about twenty carrier periods, and raising it again. It also uses a modulation pulse shorter than one carrier period, which never reaches the gate but still starts a full release window. A behavioural model, stepped every clock, predicts each output, and a directed count confirms the exact release tick count.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_FAULT  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic shd;
        logic mod;
        logic shrt;
    } ctl_in_t;

    typedef struct packed {
        logic a_oe;
        logic a_dat;
        logic b_oe;
        logic b_dat;
    } drv_pair_t;

    typedef struct packed {
        logic oe;
        logic dat;
        logic pulldn;
    } rc_pin_t;

    localparam int CTL_W = $bits(ctl_in_t);
    localparam ctl_in_t CTL_RST = '{shd: 1'b1, mod: 1'b0, shrt: 1'b0};

    function automatic logic field_state(input seq_state_e s);
        return (s == ST_SETTLE) || (s == ST_RUN);
    endfunction

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/lfr_sync.sv
module lfr_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lfr_fsm.sv
module lfr_fsm
    import lfr_pkg::*;
#(
    parameter int SETTLE_TICKS = 3125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       shd,
    input  logic       shrt,
    output seq_state_e state,
    output logic       keep_field
);
    localparam int CW = cnt_width(SETTLE_TICKS);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    seq_state_e    nxt;
    logic [CW-1:0] cnt_q;

    always_comb begin
        nxt = state;
        if (shd) begin
            nxt = ST_SLEEP;
        end else begin
            unique case (state)
                ST_SLEEP:  nxt = ST_SETTLE;
                ST_SETTLE: begin
                    if (shrt)                      nxt = ST_FAULT;
                    else if (tick && cnt_q == LAST) nxt = ST_RUN;
                end
                ST_RUN:    if (shrt) nxt = ST_FAULT;
                ST_FAULT:  nxt = ST_FAULT;
                default:   nxt = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SLEEP;
            cnt_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_SETTLE && nxt == ST_SETTLE)
                cnt_q <= tick ? cnt_q + 1'b1 : cnt_q;
            else
                cnt_q <= '0;
        end
    end

    assign keep_field = field_state(state) && !shd && !shrt;
endmodule

// File: rtl/lfr_gate.sv
module lfr_gate
    import lfr_pkg::*;
#(
    parameter int REL_TICKS = 41
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic mod,
    input  logic keep_field,
    output logic gate_off,
    output logic hold
);
    localparam int RW = cnt_width(REL_TICKS);
    localparam logic [RW-1:0] RELOAD = RW'(REL_TICKS);

    logic [RW-1:0] rel_q;

    always_ff @(posedge clk) begin
        if (rst || !keep_field) begin
            gate_off <= 1'b0;
            rel_q    <= '0;
        end else begin
            if (tick) gate_off <= mod;
            if (mod)
                rel_q <= RELOAD;
            else if (tick && rel_q != '0)
                rel_q <= rel_q - 1'b1;
        end
    end

    assign hold = (rel_q != '0);
endmodule

// File: rtl/lfr_pins.sv
module lfr_pins
    import lfr_pkg::*;
(
    input  seq_state_e state,
    input  logic       gate_off,
    input  logic       am_single,
    input  logic       car_lvl,
    output drv_pair_t  drv,
    output rc_pin_t    rc,
    output logic       rx_en
);
    logic field_on;

    always_comb begin
        field_on  = field_state(state);
        rx_en     = field_on;
        drv.a_dat = car_lvl;
        drv.b_dat = ~car_lvl;
        drv.a_oe  = field_on && !gate_off;
        drv.b_oe  = field_on && (am_single || !gate_off);
        unique case (state)
            ST_SETTLE: rc = '{oe: 1'b0, dat: 1'b0,    pulldn: 1'b1};
            ST_RUN:    rc = '{oe: 1'b1, dat: car_lvl, pulldn: 1'b0};
            default:   rc = '{oe: 1'b1, dat: 1'b0,    pulldn: 1'b0};
        endcase
    end
endmodule

// File: rtl/lfr_carrier_seq.sv
module lfr_carrier_seq
    import lfr_pkg::*;
#(
    parameter int SETTLE_TICKS = 3125,
    parameter int REL_TICKS = 41,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic car_lvl,
    input  logic car_tick,
    input  logic sleep_req,
    input  logic mod_req,
    input  logic short_flag,
    input  logic am_single,
    output logic ant_a_oe,
    output logic ant_a_dat,
    output logic ant_b_oe,
    output logic ant_b_dat,
    output logic rc_oe,
    output logic rc_dat,
    output logic rc_pulldn,
    output logic rx_en,
    output logic rx_hold
);
    ctl_in_t    ctl_raw, ctl_s;
    seq_state_e state;
    logic       keep_field, gate_off;
    logic       shd_s, mod_s, shrt_s;
    drv_pair_t  drv;
    rc_pin_t    rc;

    assign ctl_raw = '{shd: sleep_req, mod: mod_req, shrt: short_flag};

    lfr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    assign shd_s  = ctl_s.shd;
    assign mod_s  = ctl_s.mod;
    assign shrt_s = ctl_s.shrt;

    lfr_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
        .clk(clk), .rst(rst), .tick(car_tick), .shd(shd_s), .shrt(shrt_s),
        .state(state), .keep_field(keep_field)
    );

    lfr_gate #(.REL_TICKS(REL_TICKS)) u_gate (
        .clk(clk), .rst(rst), .tick(car_tick), .mod(mod_s),
        .keep_field(keep_field), .gate_off(gate_off), .hold(rx_hold)
    );

    lfr_pins u_pins (
        .state(state), .gate_off(gate_off), .am_single(am_single),
        .car_lvl(car_lvl), .drv(drv), .rc(rc), .rx_en(rx_en)
    );

    assign ant_a_oe  = drv.a_oe;
    assign ant_a_dat = drv.a_dat;
    assign ant_b_oe  = drv.b_oe;
    assign ant_b_dat = drv.b_dat;
    assign rc_oe     = rc.oe;
    assign rc_dat    = rc.dat;
    assign rc_pulldn = rc.pulldn;
endmodule

// File: rtl/lfr_carrier_seq_chk.sv
module lfr_carrier_seq_chk
    import lfr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       car_lvl,
    input logic       car_tick,
    input logic       shd_s,
    input logic       mod_s,
    input logic       shrt_s,
    input seq_state_e state,
    input logic       ant_a_oe,
    input logic       ant_b_oe,
    input logic       rc_oe,
    input logic       rc_dat,
    input logic       rx_en,
    input logic       rx_hold
);
    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        shd_s |=> (!ant_a_oe && !ant_b_oe && rc_oe && !rc_dat && !rx_en && !rx_hold));

    p_gate_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !car_tick && !shd_s && !shrt_s) |=> $stable(ant_a_oe));

    p_hold_while_mod_r6: assert property (@(posedge clk) disable iff (rst)
        (mod_s && rx_en && !shd_s && !shrt_s) |=> rx_hold);

    p_hold_release_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_hold) |-> ($past(car_tick) || !rx_en));

    p_run_clock_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !shd_s && !shrt_s) |=> (rc_oe && rc_dat == car_lvl));

    p_short_trip_r9: assert property (@(posedge clk) disable iff (rst)
        (shrt_s && rx_en && !shd_s) |=> (!ant_a_oe && !ant_b_oe && !rx_en && rc_oe && !rc_dat));

    p_fault_latch_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT && !shd_s) |=> (state == ST_FAULT));
endmodule

bind lfr_carrier_seq lfr_carrier_seq_chk u_chk (
    .clk(clk), .rst(rst), .car_lvl(car_lvl), .car_tick(car_tick),
    .shd_s(shd_s), .mod_s(mod_s), .shrt_s(shrt_s), .state(state),
    .ant_a_oe(ant_a_oe), .ant_b_oe(ant_b_oe), .rc_oe(rc_oe), .rc_dat(rc_dat),
    .rx_en(rx_en), .rx_hold(rx_hold)
);

// File: tb/sim_lfr_carrier_seq.sv
module sim_lfr_carrier_seq;
    localparam int SETTLE = 12;
    localparam int REL = 41;
    localparam int CP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_lvl = 1'b1, car_tick = 1'b1;
    logic sleep_req = 1'b1, mod_req = 1'b0, short_flag = 1'b0, am_single = 1'b0;
    logic ant_a_oe, ant_a_dat, ant_b_oe, ant_b_dat, rc_oe, rc_dat, rc_pulldn, rx_en, rx_hold;

    int n_chk = 0, n_fail = 0, cpos = 0;

    lfr_carrier_seq #(.SETTLE_TICKS(SETTLE), .REL_TICKS(REL)) u0 (
        .clk(clk), .rst(rst), .car_lvl(car_lvl), .car_tick(car_tick),
        .sleep_req(sleep_req), .mod_req(mod_req), .short_flag(short_flag),
        .am_single(am_single), .ant_a_oe(ant_a_oe), .ant_a_dat(ant_a_dat),
        .ant_b_oe(ant_b_oe), .ant_b_dat(ant_b_dat), .rc_oe(rc_oe), .rc_dat(rc_dat),
        .rc_pulldn(rc_pulldn), .rx_en(rx_en), .rx_hold(rx_hold)
    );

    always #5 clk = ~clk;

    // behavioural reference: 0 sleep, 1 settle, 2 run, 3 fault
    int ms = 0, mcnt = 0, mrel = 0;
    bit mgate = 0;
    bit shd1 = 1, shd2 = 1, mod1 = 0, mod2 = 0, sh1 = 0, sh2 = 0;

    always @(posedge clk) begin
        int old;
        bit act;
        if (rst) begin
            ms = 0; mcnt = 0; mrel = 0; mgate = 0;
            shd1 = 1; shd2 = 1; mod1 = 0; mod2 = 0; sh1 = 0; sh2 = 0;
        end else begin
            old = ms;
            act = (ms == 1 || ms == 2);
            if (shd2) ms = 0;
            else if (ms == 0) ms = 1;
            else if (ms == 1) begin
                if (sh2) ms = 3;
                else if (car_tick && mcnt == SETTLE - 1) ms = 2;
            end else if (ms == 2 && sh2) ms = 3;
            if (old == 1 && ms == 1) begin
                if (car_tick) mcnt++;
            end else mcnt = 0;
            if (act && !shd2 && !sh2) begin
                if (car_tick) mgate = mod2;
                if (mod2) mrel = REL;
                else if (car_tick && mrel > 0) mrel--;
            end else begin
                mgate = 0; mrel = 0;
            end
            shd2 = shd1; shd1 = sleep_req;
            mod2 = mod1; mod1 = mod_req;
            sh2 = sh1;   sh1 = short_flag;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        bit on;
        logic [3:0] e_drv, a_drv;
        logic [2:0] e_rc, a_rc;
        logic [1:0] e_rx, a_rx;
        on = (ms == 1 || ms == 2);
        e_drv = {on && !mgate, car_lvl, on && (am_single || !mgate), ~car_lvl};
        a_drv = {ant_a_oe, ant_a_dat, ant_b_oe, ant_b_dat};
        if (ms == 2)      e_rc = {1'b1, car_lvl, 1'b0};
        else if (ms == 1) e_rc = 3'b001;
        else              e_rc = 3'b100;
        a_rc = {rc_oe, rc_dat, rc_pulldn};
        e_rx = {on, mrel != 0};
        a_rx = {rx_en, rx_hold};
        check(a_drv === e_drv, "R4 R5 R8 antenna drivers", a_drv, e_drv);
        check(a_rc === e_rc, "R3 R7 ready/clock pin", a_rc, e_rc);
        check(a_rx === e_rx, "R6 R9 chain enable/hold", a_rx, e_rx);
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) compare_model();
        cpos = (cpos + 1) % CP;
        car_lvl = (cpos < CP / 2);
        car_tick = (cpos == 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wake_and_settle();
        sleep_req = 1'b0;
        steps(SETTLE * CP + 3 * CP);
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        steps(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ticks;
        bit t;
        steps(4);
        rst = 1'b0;
        steps(3);
        // R1 reset state
        check(!ant_a_oe && !ant_b_oe && rc_oe && !rc_dat && !rc_pulldn && !rx_en && !rx_hold,
              "R1 sleep after reset", {ant_a_oe, ant_b_oe, rc_oe, rc_dat, rx_en}, 5'b00100);
        // R9 short while asleep ignored
        short_flag = 1'b1; steps(10); short_flag = 1'b0; steps(4);
        // R3 settling then run, bridge mode
        sleep_req = 1'b0;
        steps(CP * 2);
        check(!rc_oe && rc_pulldn && rx_en, "R3 settling weak pull-down",
              {rc_oe, rc_pulldn, rx_en}, 3'b011);
        steps(SETTLE * CP + CP);
        check(rc_oe && !rc_pulldn, "R3 running drives clock", {rc_oe, rc_pulldn}, 2'b10);
        // R6 exact release count, mod drops one cycle after a tick
        mod_req = 1'b1;
        steps(5 * CP);
        check(!ant_a_oe && !ant_b_oe && rx_hold, "R8 bridge gated field",
              {ant_a_oe, ant_b_oe, rx_hold}, 3'b001);
        while (cpos != 1) step();
        mod_req = 1'b0;
        ticks = 0;
        for (int i = 0; i < REL * CP + 40; i++) begin
            t = car_tick;
            step();
            if (t) ticks++;
            if (!rx_hold) break;
        end
        check(ticks == REL, "R6 release tick count", ticks, REL);
        // mod pulse mid-period, re-request inside release window
        steps(3);
        mod_req = 1'b1; steps(11); mod_req = 1'b0;
        steps(20 * CP + 3);
        mod_req = 1'b1; steps(2 * CP); mod_req = 1'b0;
        steps(REL * CP + 2 * CP);
        // pulse shorter than a carrier period
        while (cpos != 2) step();
        mod_req = 1'b1; steps(3); mod_req = 1'b0;
        steps(REL * CP + 2 * CP);
        check(!rx_hold && ant_a_oe, "R6 short pulse released", {rx_hold, ant_a_oe}, 2'b01);
        // R9 short in run, latched
        short_flag = 1'b1; steps(4); short_flag = 1'b0;
        steps(60);
        check(!ant_a_oe && !ant_b_oe && rc_oe && !rc_dat && !rx_en, "R9 fault latched",
              {ant_a_oe, ant_b_oe, rc_oe, rc_dat, rx_en}, 5'b00100);
        // R2 sleep clears fault
        go_sleep();
        check(rc_oe && !rc_dat && !rx_en, "R2 sleep clears fault", {rc_oe, rc_dat, rx_en}, 3'b100);
        // R8 single-ended AM mode
        am_single = 1'b1;
        wake_and_settle();
        mod_req = 1'b1; steps(3 * CP);
        check(!ant_a_oe && ant_b_oe && rc_oe, "R8 AM keeps second driver",
              {ant_a_oe, ant_b_oe, rc_oe}, 3'b011);
        check(rx_hold, "R7 R6 hold during AM modulation", rx_hold, 1);
        // R2 sleep during modulation
        go_sleep();
        mod_req = 1'b0;
        check(!ant_a_oe && !ant_b_oe && !rx_hold, "R2 sleep during modulation",
              {ant_a_oe, ant_b_oe, rx_hold}, 3'b000);
        // R9 short during settling
        am_single = 1'b0;
        sleep_req = 1'b0; steps(3 * CP);
        short_flag = 1'b1; steps(5); short_flag = 1'b0;
        steps(SETTLE * CP + CP);
        check(!rx_en && rc_oe && !rc_pulldn, "R9 fault from settling",
              {rx_en, rc_oe, rc_pulldn}, 3'b010);
        go_sleep();
        wake_and_settle();
        check(rc_oe && rx_en, "R3 recovers after fault", {rc_oe, rx_en}, 2'b11);
        steps(10);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule